// File: doc/BRIEF.md
# Chipset Power Mode Controller

This controller steps a host bridge and memory controller through four power levels: full-on, nap, sleep and suspend. Software asks for nap or sleep with a one-cycle strobe that carries the target level. The request waits until the bus reports idle. While the block is in a low-power level it drives a separate enable for each unit: address decode, memory refresh, bus-request monitor, and the remaining logic.

Wake-up depends on the level and on what caused it. In nap, a PCI hit on system memory is served for one granted cycle and the block then drops back to nap without being asked. A processor bus request is granted and leaves the block in full-on. Sleep ignores PCI hits. A processor request wakes it, but the block first waits a programmable number of cycles for the clock to lock. The suspend pin overrides everything else. While it is held, every input is ignored (hard reset included), the outputs are released, and refresh either comes from an external tick or is left to self-refreshing memory. Releasing the pin also goes through the lock wait.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the asynchronous reset `rstN`, `mode` reads 0 (full-on), all four unit enables are high, and `accessGrant`, `outTriState`, `refreshSel` and `rtcRefresh` are low.
- R2: In full-on, a `reqValid` strobe with `reqMode` 1 (nap) or 2 (sleep) is held pending. The block enters the target level on the first clock edge after the strobe at which `busIdle` is high. `reqMode` values 0 and 3 are ignored.
- R3: In nap, `mode` reads 1. `enDecode`, `enRefresh` and `enBusMon` are high and `enOther` is low.
- R4: In nap, a `pciMemHit` without `cpuBusReq` gives one cycle with `mode` 0, all enables high and `accessGrant` high. The block then returns to nap with no new request.
- R5: In nap, a `cpuBusReq` gives one granted cycle with all enables high. The block then stays in full-on. It takes precedence over a simultaneous `pciMemHit`. `accessGrant` is never high for two cycles in a row.
- R6: In sleep, `mode` reads 2. `enDecode`, `enBusMon` and `enOther` are low, and `enRefresh` follows `refreshCfgEn`.
- R7: Sleep ignores `pciMemHit`. A `cpuBusReq` starts a lock wait of `lockWait`+1 cycles with `mode` 0, only `enRefresh` high and no grant. One granted cycle follows, then full-on.
- R8: A high `suspendPin` moves the block to suspend (`mode` 3) at the next edge from any level. While suspended, `hardRst` and all other requests are ignored. `outTriState` is high only in suspend.
- R9: In suspend with `selfRefreshSel` 0, `refreshSel` is high and `rtcRefresh` follows `rtcTick`. With `selfRefreshSel` 1, both are low.
- R10: When `suspendPin` is negated, the block runs the R7 lock wait, then one granted cycle, then full-on.
- R11: `hardRst` outside suspend forces full-on at the next edge from any level, the lock wait included, with no grant. It also discards a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hardRst | input | 1 | Hard reset request, synchronous |
| suspendPin | input | 1 | Suspend level |
| reqValid | input | 1 | Mode request strobe |
| reqMode | input | 2 | Requested level: 1 nap, 2 sleep |
| busIdle | input | 1 | Bus is idle |
| pciMemHit | input | 1 | PCI access targets system memory |
| cpuBusReq | input | 1 | Processor bus request |
| refreshCfgEn | input | 1 | Keep refresh running in sleep |
| selfRefreshSel | input | 1 | Suspend refresh left to self-refresh memory |
| rtcTick | input | 1 | External refresh tick |
| lockWait | input | CNT_W | Lock wait length minus one |
| enDecode | output | 1 | Address decode enable |
| enRefresh | output | 1 | Refresh logic enable |
| enBusMon | output | 1 | Bus-request monitor enable |
| enOther | output | 1 | Enable for remaining logic |
| refreshSel | output | 1 | Refresh is driven by the external tick |
| rtcRefresh | output | 1 | Refresh strobe issued from a tick |
| outTriState | output | 1 | Release the block's outputs |
| accessGrant | output | 1 | One-cycle access grant |
| mode | output | 2 | Current level: 0 full, 1 nap, 2 sleep, 3 suspend |

## Verification
The assertions check the following on every cycle:
- the unit enables for nap and sleep;
- suspend entry on the pin, and that the release control is seen only in suspend;
- that hard reset and PCI hits are ignored where they must be;
- that the grant lasts exactly one cycle;
- that a tick-driven refresh happens only in suspend.

Other behaviour needs whole sequences, which only the bench scenarios can show. That covers:
- a request waiting for an idle bus;
- the automatic return to nap after a PCI-served access;
- the exact length of the lock wait for different `lockWait` values;
- a request discarded by a hard reset.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_NAP   = 2'd1,
    MODE_SLEEP = 2'd2,
    MODE_SUSP  = 2'd3
  } pmode_t;

  typedef enum logic [2:0] {
    ST_FULL,
    ST_NAP,
    ST_SERVE,
    ST_SLEEP,
    ST_LOCK,
    ST_SUSP
  } pstate_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setPend;
    logic clrPend;
    logic loadCnt;
    logic decCnt;
  } dpStrobe_t;

endpackage

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [1:0]       reqMode,
  input  logic [CNT_W-1:0] lockWait,
  input  logic             inSusp,
  input  logic             selfRefreshSel,
  input  logic             rtcTick,
  output logic             pendValid,
  output pmode_t           pendMode,
  output logic             cntZero,
  output logic             refreshSel,
  output logic             rtcRefresh
);

  logic [CNT_W-1:0] lockCnt;

  // pending low-power request; clear wins over set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendMode  <= MODE_FULL;
    end else if (strb.clrPend) begin
      pendValid <= 1'b0;
    end else if (strb.setPend) begin
      pendValid <= 1'b1;
      pendMode  <= pmode_t'(reqMode);
    end
  end

  // clock-lock wait counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt <= '0;
    end else if (strb.loadCnt) begin
      lockCnt <= lockWait;
    end else if (strb.decCnt) begin
      lockCnt <= lockCnt - 1'b1;
    end
  end

  assign cntZero = (lockCnt == '0);

  // refresh source while suspended
  assign refreshSel = inSusp && !selfRefreshSel;
  assign rtcRefresh = refreshSel && rtcTick;

endmodule

// File: rtl/pmc_control.sv
module pmc_control
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hardRst,
  input  logic       suspendPin,
  input  logic       reqValid,
  input  logic [1:0] reqMode,
  input  logic       busIdle,
  input  logic       pciMemHit,
  input  logic       cpuBusReq,
  input  logic       refreshCfgEn,
  input  logic       pendValid,
  input  pmode_t     pendMode,
  input  logic       cntZero,
  output dpStrobe_t  strb,
  output logic       inSusp,
  output logic       enDecode,
  output logic       enRefresh,
  output logic       enBusMon,
  output logic       enOther,
  output logic       outTriState,
  output logic       accessGrant,
  output pmode_t     mode
);

  pstate_t state, stateNxt;
  logic    retNap, retNapNxt;
  logic    reqOk;

  assign reqOk = reqValid && (reqMode == MODE_NAP || reqMode == MODE_SLEEP);

  always_comb begin
    stateNxt  = state;
    retNapNxt = retNap;
    strb      = '0;
    if (suspendPin) begin
      stateNxt     = ST_SUSP;
      strb.clrPend = 1'b1;
    end else if (state == ST_SUSP) begin
      stateNxt     = ST_LOCK;
      strb.loadCnt = 1'b1;
    end else if (hardRst) begin
      stateNxt     = ST_FULL;
      strb.clrPend = 1'b1;
    end else begin
      unique case (state)
        ST_FULL: begin
          if (pendValid && busIdle) begin
            stateNxt     = (pendMode == MODE_SLEEP) ? ST_SLEEP : ST_NAP;
            strb.clrPend = 1'b1;
          end else if (reqOk) begin
            strb.setPend = 1'b1;
          end
        end
        ST_NAP: begin
          if (cpuBusReq) begin
            stateNxt  = ST_SERVE;
            retNapNxt = 1'b0;
          end else if (pciMemHit) begin
            stateNxt  = ST_SERVE;
            retNapNxt = 1'b1;
          end
        end
        ST_SERVE: stateNxt = retNap ? ST_NAP : ST_FULL;
        ST_SLEEP: begin
          if (cpuBusReq) begin
            stateNxt     = ST_LOCK;
            strb.loadCnt = 1'b1;
          end
        end
        ST_LOCK: begin
          if (cntZero) begin
            stateNxt  = ST_SERVE;
            retNapNxt = 1'b0;
          end else begin
            strb.decCnt = 1'b1;
          end
        end
        default: stateNxt = ST_FULL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_FULL;
      retNap <= 1'b0;
    end else begin
      state  <= stateNxt;
      retNap <= retNapNxt;
    end
  end

  // per-state unit enables and status
  always_comb begin
    enDecode    = 1'b0;
    enRefresh   = 1'b0;
    enBusMon    = 1'b0;
    enOther     = 1'b0;
    outTriState = 1'b0;
    accessGrant = 1'b0;
    mode        = MODE_FULL;
    unique case (state)
      ST_FULL, ST_SERVE: begin
        enDecode    = 1'b1;
        enRefresh   = 1'b1;
        enBusMon    = 1'b1;
        enOther     = 1'b1;
        accessGrant = (state == ST_SERVE);
      end
      ST_NAP: begin
        enDecode  = 1'b1;
        enRefresh = 1'b1;
        enBusMon  = 1'b1;
        mode      = MODE_NAP;
      end
      ST_SLEEP: begin
        enRefresh = refreshCfgEn;
        mode      = MODE_SLEEP;
      end
      ST_LOCK: enRefresh = 1'b1;
      ST_SUSP: begin
        outTriState = 1'b1;
        mode        = MODE_SUSP;
      end
      default: ;
    endcase
  end

  assign inSusp = (state == ST_SUSP);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hardRst,
  input  logic             suspendPin,
  input  logic             reqValid,
  input  logic [1:0]       reqMode,
  input  logic             busIdle,
  input  logic             pciMemHit,
  input  logic             cpuBusReq,
  input  logic             refreshCfgEn,
  input  logic             selfRefreshSel,
  input  logic             rtcTick,
  input  logic [CNT_W-1:0] lockWait,
  output logic             enDecode,
  output logic             enRefresh,
  output logic             enBusMon,
  output logic             enOther,
  output logic             refreshSel,
  output logic             rtcRefresh,
  output logic             outTriState,
  output logic             accessGrant,
  output logic [1:0]       mode
);

  dpStrobe_t strb;
  logic      pendValid, cntZero, inSusp;
  pmode_t    pendMode, modeInt;

  pmc_control u_ctrl (
    .clk(clk), .rstN(rstN), .hardRst(hardRst), .suspendPin(suspendPin),
    .reqValid(reqValid), .reqMode(reqMode), .busIdle(busIdle),
    .pciMemHit(pciMemHit), .cpuBusReq(cpuBusReq), .refreshCfgEn(refreshCfgEn),
    .pendValid(pendValid), .pendMode(pendMode), .cntZero(cntZero),
    .strb(strb), .inSusp(inSusp), .enDecode(enDecode), .enRefresh(enRefresh),
    .enBusMon(enBusMon), .enOther(enOther), .outTriState(outTriState),
    .accessGrant(accessGrant), .mode(modeInt)
  );

  pmc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqMode(reqMode),
    .lockWait(lockWait), .inSusp(inSusp), .selfRefreshSel(selfRefreshSel),
    .rtcTick(rtcTick), .pendValid(pendValid), .pendMode(pendMode),
    .cntZero(cntZero), .refreshSel(refreshSel), .rtcRefresh(rtcRefresh)
  );

  assign mode = modeInt;

endmodule

// File: rtl/pwr_mode_ctrl_sva.sv
module pmc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hardRst,
  input logic       suspendPin,
  input logic       pciMemHit,
  input logic       cpuBusReq,
  input logic       refreshCfgEn,
  input logic       rtcTick,
  input logic       enDecode,
  input logic       enRefresh,
  input logic       enBusMon,
  input logic       enOther,
  input logic       refreshSel,
  input logic       rtcRefresh,
  input logic       outTriState,
  input logic       accessGrant,
  input logic [1:0] mode
);

  assert_nap_units_R3: assert property (@(posedge clk) disable iff (!rstN)
    mode == 2'd1 |-> enDecode && enRefresh && enBusMon && !enOther);

  assert_grant_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    accessGrant |=> !accessGrant);

  assert_sleep_units_R6: assert property (@(posedge clk) disable iff (!rstN)
    mode == 2'd2 |-> !enDecode && !enBusMon && !enOther && (enRefresh == refreshCfgEn));

  assert_sleep_ignores_pci_R7: assert property (@(posedge clk) disable iff (!rstN)
    mode == 2'd2 && pciMemHit && !cpuBusReq && !hardRst && !suspendPin |=> mode == 2'd2);

  assert_suspend_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    suspendPin |=> mode == 2'd3 && outTriState);

  assert_release_only_susp_R8: assert property (@(posedge clk) disable iff (!rstN)
    outTriState |-> mode == 2'd3);

  assert_tick_refresh_R9: assert property (@(posedge clk) disable iff (!rstN)
    rtcRefresh |-> outTriState && refreshSel && rtcTick);

  assert_hard_reset_R11: assert property (@(posedge clk) disable iff (!rstN)
    hardRst && !suspendPin && mode != 2'd3 |=> mode == 2'd0 && !accessGrant);

endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk(clk), .rstN(rstN), .hardRst(hardRst), .suspendPin(suspendPin),
  .pciMemHit(pciMemHit), .cpuBusReq(cpuBusReq), .refreshCfgEn(refreshCfgEn),
  .rtcTick(rtcTick), .enDecode(enDecode), .enRefresh(enRefresh),
  .enBusMon(enBusMon), .enOther(enOther), .refreshSel(refreshSel),
  .rtcRefresh(rtcRefresh), .outTriState(outTriState),
  .accessGrant(accessGrant), .mode(mode)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  // input pattern: hardRst suspendPin reqValid reqMode[1:0] busIdle pciMemHit cpuBusReq refreshCfgEn selfRefreshSel rtcTick
  localparam logic [10:0] I_IDLE   = 11'b0_0_0_00_0_0_0_1_0_0;
  localparam logic [10:0] I_IBUS   = 11'b0_0_0_00_1_0_0_1_0_0;
  localparam logic [10:0] I_NAPNB  = 11'b0_0_1_01_0_0_0_1_0_0;
  localparam logic [10:0] I_NAPI   = 11'b0_0_1_01_1_0_0_1_0_0;
  localparam logic [10:0] I_SLPNB  = 11'b0_0_1_10_0_0_0_1_0_0;
  localparam logic [10:0] I_SLPI   = 11'b0_0_1_10_1_0_0_1_0_0;
  localparam logic [10:0] I_REQ3   = 11'b0_0_1_11_1_0_0_1_0_0;
  localparam logic [10:0] I_PCI    = 11'b0_0_0_00_0_1_0_1_0_0;
  localparam logic [10:0] I_CPU    = 11'b0_0_0_00_0_0_1_1_0_0;
  localparam logic [10:0] I_BOTH   = 11'b0_0_0_00_0_1_1_1_0_0;
  localparam logic [10:0] I_NOCFG  = 11'b0_0_0_00_0_0_0_0_0_0;
  localparam logic [10:0] I_SUSP   = 11'b0_1_0_00_0_0_0_1_0_0;
  localparam logic [10:0] I_SUSPT  = 11'b0_1_0_00_0_0_0_1_0_1;
  localparam logic [10:0] I_SUSPH  = 11'b1_1_0_00_0_0_0_1_0_0;
  localparam logic [10:0] I_SUSPS  = 11'b0_1_0_00_0_0_0_1_1_1;
  localparam logic [10:0] I_HARD   = 11'b1_0_0_00_0_0_0_1_0_0;

  // expected: mode[1:0] enDecode enRefresh enBusMon enOther accessGrant outTriState refreshSel rtcRefresh
  localparam logic [9:0] E_FULL  = 10'b00_1111_0000;
  localparam logic [9:0] E_NAP   = 10'b01_1110_0000;
  localparam logic [9:0] E_SERVE = 10'b00_1111_1000;
  localparam logic [9:0] E_SLP   = 10'b10_0100_0000;
  localparam logic [9:0] E_SLP0  = 10'b10_0000_0000;
  localparam logic [9:0] E_LOCK  = 10'b00_0100_0000;
  localparam logic [9:0] E_SUSP  = 10'b11_0000_0110;
  localparam logic [9:0] E_SUSPT = 10'b11_0000_0111;
  localparam logic [9:0] E_SUSPS = 10'b11_0000_0100;

  localparam int NV = 36;
  // {requirement number, inputs, expected after the edge}
  localparam logic [24:0] VEC [NV] = '{
    {4'd1,  I_IDLE,  E_FULL },   // R1
    {4'd2,  I_NAPNB, E_FULL },   // R2 strobe while busy
    {4'd2,  I_IDLE,  E_FULL },   // R2 still pending
    {4'd3,  I_IBUS,  E_NAP  },   // R3 idle -> nap
    {4'd3,  I_IDLE,  E_NAP  },   // R3
    {4'd4,  I_PCI,   E_SERVE},   // R4 pci wake
    {4'd4,  I_IDLE,  E_NAP  },   // R4 back to nap
    {4'd5,  I_CPU,   E_SERVE},   // R5 cpu wake
    {4'd5,  I_IDLE,  E_FULL },   // R5
    {4'd5,  I_IDLE,  E_FULL },   // R5 stays
    {4'd2,  I_SLPI,  E_FULL },   // R2 sleep request
    {4'd6,  I_IBUS,  E_SLP  },   // R6
    {4'd7,  I_PCI,   E_SLP  },   // R7 pci ignored
    {4'd6,  I_NOCFG, E_SLP0 },   // R6 refresh off
    {4'd7,  I_CPU,   E_LOCK },   // R7 lock 1
    {4'd7,  I_IDLE,  E_LOCK },   // R7 lock 2
    {4'd7,  I_IDLE,  E_LOCK },   // R7 lock 3
    {4'd7,  I_IDLE,  E_SERVE},   // R7 grant
    {4'd7,  I_IDLE,  E_FULL },   // R7
    {4'd8,  I_SUSP,  E_SUSP },   // R8
    {4'd9,  I_SUSPT, E_SUSPT},   // R9 tick refresh
    {4'd8,  I_SUSPH, E_SUSP },   // R8 hard reset ignored
    {4'd9,  I_SUSPS, E_SUSPS},   // R9 self refresh
    {4'd10, I_IDLE,  E_LOCK },   // R10
    {4'd10, I_IDLE,  E_LOCK },   // R10
    {4'd10, I_IDLE,  E_LOCK },   // R10
    {4'd10, I_IDLE,  E_SERVE},   // R10
    {4'd10, I_IDLE,  E_FULL },   // R10
    {4'd2,  I_NAPI,  E_FULL },   // R2
    {4'd3,  I_IBUS,  E_NAP  },   // R3
    {4'd11, I_HARD,  E_FULL },   // R11 from nap
    {4'd11, I_SLPNB, E_FULL },   // R11 set pending
    {4'd11, I_HARD,  E_FULL },   // R11 clears pending
    {4'd11, I_IBUS,  E_FULL },   // R11 nothing pending
    {4'd2,  I_REQ3,  E_FULL },   // R2 code 3 ignored
    {4'd2,  I_IBUS,  E_FULL }    // R2
  };

  logic clk = 1'b0;
  logic rstN;
  logic hardRst, suspendPin, reqValid, busIdle, pciMemHit, cpuBusReq;
  logic refreshCfgEn, selfRefreshSel, rtcTick;
  logic [1:0] reqMode;
  logic [CNT_W-1:0] lockWait;
  logic enDecode, enRefresh, enBusMon, enOther, refreshSel, rtcRefresh;
  logic outTriState, accessGrant;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.CNT_W(CNT_W)) u_pwr_mode_ctrl (
    .clk(clk), .rstN(rstN), .hardRst(hardRst), .suspendPin(suspendPin),
    .reqValid(reqValid), .reqMode(reqMode), .busIdle(busIdle),
    .pciMemHit(pciMemHit), .cpuBusReq(cpuBusReq), .refreshCfgEn(refreshCfgEn),
    .selfRefreshSel(selfRefreshSel), .rtcTick(rtcTick), .lockWait(lockWait),
    .enDecode(enDecode), .enRefresh(enRefresh), .enBusMon(enBusMon),
    .enOther(enOther), .refreshSel(refreshSel), .rtcRefresh(rtcRefresh),
    .outTriState(outTriState), .accessGrant(accessGrant), .mode(mode)
  );

  function automatic logic [9:0] observed();
    return {mode, enDecode, enRefresh, enBusMon, enOther,
            accessGrant, outTriState, refreshSel, rtcRefresh};
  endfunction

  task automatic drive(input logic [10:0] iv);
    {hardRst, suspendPin, reqValid, reqMode, busIdle, pciMemHit,
     cpuBusReq, refreshCfgEn, selfRefreshSel, rtcTick} = iv;
  endtask

  task automatic compare(input logic [9:0] ev, input int rid, input string tag);
    checks++;
    if (observed() !== ev) begin
      errors++;
      $display("FAIL R%0d %s: got %b expected %b", rid, tag, observed(), ev);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic [10:0] iv, input logic [9:0] ev, input int rid, input string tag);
    drive(iv);
    @(posedge clk);
    @(negedge clk);
    compare(ev, rid, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    lockWait = CNT_W'(2);
    drive(I_IDLE);
    repeat (3) @(negedge clk);
    compare(E_FULL, 1, "reset value R1");
    rstN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][20:10], VEC[k][9:0], int'(VEC[k][24:21]), $sformatf("vector %0d", k));
    end

    // R11: hard reset during the lock wait skips the grant
    step(I_SLPI, E_FULL, 11, "R11 request");
    step(I_IBUS, E_SLP,  11, "R11 sleep");
    step(I_CPU,  E_LOCK, 11, "R11 lock");
    step(I_HARD, E_FULL, 11, "R11 abort lock");
    step(I_IDLE, E_FULL, 11, "R11 no grant");

    // R10: zero lock wait gives a single lock cycle
    lockWait = '0;
    step(I_SUSP, E_SUSP,  10, "R10 enter");
    step(I_IDLE, E_LOCK,  10, "R10 lock one");
    step(I_IDLE, E_SERVE, 10, "R10 grant");
    step(I_IDLE, E_FULL,  10, "R10 full");

    // R5: processor wins over a simultaneous PCI hit
    step(I_NAPI, E_FULL,  5, "R5 request");
    step(I_IBUS, E_NAP,   5, "R5 nap");
    step(I_BOTH, E_SERVE, 5, "R5 both wake");
    step(I_IDLE, E_FULL,  5, "R5 stays full");

    // R1: asynchronous reset from nap
    step(I_NAPI, E_FULL, 1, "R1 request");
    step(I_IBUS, E_NAP,  1, "R1 nap");
    rstN = 1'b0;
    #1;
    compare(E_FULL, 1, "R1 async reset");
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule